// File: doc/BRIEF.md
# SDRAM Command Controller with Periodic Refresh

This block sits between a simple host request port and a single-data-rate SDRAM device. The device has four banks, 13-bit row addresses, 9-bit column addresses and a 16-bit data bus. The host presents one read or one write at a time. The host address is packed as `{bank[1:0], row[12:0], col[8:0]}`. The controller turns each request into the device command sequence: bank activate, then read or write, with a single-bank precharge whenever a different row must be opened. Only one row is open at any time. For reads, the controller returns the data word on the host side after the CAS latency.

After reset the controller holds clock enable low for a power-up wait. It then raises clock enable and runs the initialisation sequence: precharge all banks, two auto-refreshes, and a mode-register load. The mode-register load selects burst length one, sequential ordering, and a CAS latency of 2 or 3 taken from `cfg_cas3`. A refresh timer then counts a parameterised interval, 390 clocks by default, which is 7.8 µs at 50 MHz. When the timer expires, the controller lets the current access complete. It then closes any open row with a precharge-all and issues an auto-refresh before serving further host requests.

All minimum command spacings are parameters in clocks, and a wait counter enforces them: activate-to-access, precharge period, row cycle and mode-register delay.

Top module: `sdram_cmd_ctrl`

## Requirements
- R1: Every command cycle drives `{cs_n,ras_n,cas_n,we_n}` with one of these codes: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO REFRESH 0001, LOAD MODE 0000.
- R2: During reset, `sd_cke` and `init_done` are low and the bus carries NOP. Before the first command, `sd_cke` has been high for at least one full cycle. The first commands are, in order: precharge with A10 high, auto-refresh, auto-refresh, load mode. The load-mode word has A[3:0] = 0000. No activate, read or write is issued and `init_done` stays low until that sequence is complete.
- R3: ACTIVE carries the request's bank on `sd_ba` and its row on `sd_addr`. READ and WRITE carry the bank on `sd_ba`, the column on `sd_addr[8:0]` and A10 low, and address the row that is currently open.
- R4: A precharge with A10 high closes all banks. When a request needs a different row, the open row is closed by a precharge with A10 low and `sd_ba` set to the open bank.
- R5: A request to the bank and row already open is issued as READ or WRITE with no new ACTIVE.
- R6: Spacing on the bus: ACTIVE to READ/WRITE is at least T_RCD. PRECHARGE to ACTIVE or AUTO REFRESH is at least T_RP. ACTIVE or AUTO REFRESH to the next ACTIVE or AUTO REFRESH is at least T_RC. LOAD MODE to the next ACTIVE is at least T_MRD. Any command is followed by at least one NOP.
- R7: For a READ sampled at clock edge E, the controller captures `sd_dq_in` at edge E+CL. `rd_valid` is then high for exactly one cycle with that word on `rd_data`, in request order.
- R8: WRITE drives the request data on `sd_dq_out` with `sd_dq_oe` high in the same cycle. `sd_dqm` equals `req_wmask` for that write, where bit 0 masks the low byte and bit 1 masks the high byte when set. `sd_dq_oe` is low in every other cycle.
- R9: Once initialised, the controller issues an AUTO REFRESH at least every REFI plus a bounded access delay, with all banks closed at that moment. When no access is in progress, refreshes arrive every REFI clocks.
- R10: `req_ready` is high only while `req_valid` is high, and each high cycle produces exactly one READ or WRITE command.
- R11: The load-mode word carries the CAS latency in A[6:4]: 011 when `cfg_cas3` is high, 010 when it is low. Read capture then uses that latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cas3 | input | 1 | CAS latency select, 1 = 3 and 0 = 2, latched at mode load |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | {bank, row, column} |
| req_wdata | input | 16 | Write data |
| req_wmask | input | 2 | Byte mask for the write, 1 = byte not written |
| req_ready | output | 1 | Request accepted this cycle |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 16 | Read data |
| init_done | output | 1 | Initialisation finished |
| sd_cke | output | 1 | Device clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 13 | Multiplexed row/column/mode address |
| sd_dqm | output | 2 | Byte data masks |
| sd_dq_out | output | 16 | Data driven toward the device |
| sd_dq_oe | output | 1 | Output enable for `sd_dq_out` |
| sd_dq_in | input | 16 | Data returned by the device |

## Verification
The in-RTL properties watch, on every cycle, the command-level rules:
- clock enable is high before the first command;
- no access is issued before initialisation;
- a NOP follows every command;
- `rd_valid` is a single-cycle pulse;
- an acceptance occurs only under a valid request;
- refresh happens only with the row closed.

Only the bench's scenarios can show the rest, using a behavioural device model that stores the written data. This covers:
- correct row and column multiplexing;
- byte masking reaching memory;
- read data returning at exactly CL edges for both latencies;
- single-bank versus all-bank precharge choice on a row change;
- row hits that skip the activate;
- refresh spacing over long idle stretches and over access bursts.

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl #(
  parameter int ROW_W  = 13,
  parameter int COL_W  = 9,
  parameter int BANK_W = 2,
  parameter int DQ_W   = 16,
  parameter int T_INIT = 10,
  parameter int T_RCD  = 2,
  parameter int T_RP   = 2,
  parameter int T_RC   = 6,
  parameter int T_MRD  = 2,
  parameter int T_WR   = 2,
  parameter int REFI   = 390
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_cas3,
  input  logic                            req_valid,
  input  logic                            req_write,
  input  logic [BANK_W+ROW_W+COL_W-1:0]   req_addr,
  input  logic [DQ_W-1:0]                 req_wdata,
  input  logic [DQ_W/8-1:0]               req_wmask,
  output logic                            req_ready,
  output logic                            rd_valid,
  output logic [DQ_W-1:0]                 rd_data,
  output logic                            init_done,
  output logic                            sd_cke,
  output logic                            sd_cs_n,
  output logic                            sd_ras_n,
  output logic                            sd_cas_n,
  output logic                            sd_we_n,
  output logic [BANK_W-1:0]               sd_ba,
  output logic [ROW_W-1:0]                sd_addr,
  output logic [DQ_W/8-1:0]               sd_dqm,
  output logic [DQ_W-1:0]                 sd_dq_out,
  output logic                            sd_dq_oe,
  input  logic [DQ_W-1:0]                 sd_dq_in
);
  localparam int AW = BANK_W + ROW_W + COL_W;
  localparam int MW = DQ_W / 8;
  localparam int WW = $clog2(T_INIT + T_RC + T_RP + T_MRD + T_WR + 8);
  localparam int FW = $clog2(REFI + 1);

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_RD  = 4'b0101;
  localparam logic [3:0] C_WR  = 4'b0100;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_LMR = 4'b0000;

  logic [3:0]        cmd_q, nx_cmd;
  logic [BANK_W-1:0] nx_ba, obank_q;
  logic [ROW_W-1:0]  nx_a, orow_q;
  logic [WW-1:0]     wait_q, rc_q, nx_wait;
  logic              nx_load;
  logic [2:0]        step_q, rsh_q;
  logic              init_q, cl3_q, open_q, ref_pend_q;
  logic [FW-1:0]     refi_q;

  wire [BANK_W-1:0] rq_bank = req_addr[AW-1 -: BANK_W];
  wire [ROW_W-1:0]  rq_row  = req_addr[COL_W +: ROW_W];
  wire [COL_W-1:0]  rq_col  = req_addr[COL_W-1:0];
  wire              hit     = open_q && (obank_q == rq_bank) && (orow_q == rq_row);
  wire              cap     = cl3_q ? rsh_q[2] : rsh_q[1];

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign init_done = init_q;

  always_comb begin
    nx_cmd = C_NOP; nx_ba = '0; nx_a = '0; nx_load = 1'b0; nx_wait = '0; req_ready = 1'b0;
    if (wait_q == '0) begin
      if (!init_q) begin
        nx_load = 1'b1;
        case (step_q)
          3'd0: nx_wait = WW'(1);
          3'd1: begin nx_cmd = C_PRE; nx_a[10] = 1'b1; nx_wait = WW'(T_RP - 1); end
          3'd2, 3'd3: begin nx_cmd = C_REF; nx_wait = WW'(T_RC - 1); end
          3'd4: begin
            nx_cmd = C_LMR; nx_a[6:4] = cfg_cas3 ? 3'd3 : 3'd2; nx_wait = WW'(T_MRD - 1);
          end
          default: nx_load = 1'b0;
        endcase
      end else if (ref_pend_q) begin
        if (open_q) begin
          nx_cmd = C_PRE; nx_a[10] = 1'b1; nx_load = 1'b1; nx_wait = WW'(T_RP - 1);
        end else if (rc_q == '0) begin
          nx_cmd = C_REF; nx_load = 1'b1; nx_wait = WW'(T_RC - 1);
        end
      end else if (req_valid) begin
        if (hit) begin
          req_ready = 1'b1;
          nx_cmd = req_write ? C_WR : C_RD;
          nx_ba = rq_bank;
          nx_a[COL_W-1:0] = rq_col;
          nx_load = 1'b1;
          nx_wait = req_write ? WW'(T_WR - 1) : (cl3_q ? WW'(3) : WW'(2));
        end else if (open_q) begin
          nx_cmd = C_PRE; nx_ba = obank_q; nx_load = 1'b1; nx_wait = WW'(T_RP - 1);
        end else if (rc_q == '0) begin
          nx_cmd = C_ACT; nx_ba = rq_bank; nx_a = rq_row; nx_load = 1'b1; nx_wait = WW'(T_RCD - 1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= C_NOP; sd_ba <= '0; sd_addr <= '0; sd_cke <= 1'b0; sd_dqm <= '1;
      sd_dq_out <= '0; sd_dq_oe <= 1'b0;
      wait_q <= WW'(T_INIT - 1); rc_q <= '0; step_q <= '0; init_q <= 1'b0; cl3_q <= 1'b0;
      open_q <= 1'b0; obank_q <= '0; orow_q <= '0; ref_pend_q <= 1'b0;
      refi_q <= FW'(REFI - 1); rsh_q <= '0; rd_valid <= 1'b0; rd_data <= '0;
    end else begin
      cmd_q   <= nx_cmd;
      sd_ba   <= nx_ba;
      sd_addr <= nx_a;
      sd_dq_oe <= (nx_cmd == C_WR);
      if (nx_cmd == C_WR) sd_dq_out <= req_wdata;
      if (init_q) sd_dqm <= (nx_cmd == C_WR) ? req_wmask : {MW{1'b0}};

      if (nx_load) wait_q <= nx_wait;
      else if (wait_q != '0) wait_q <= wait_q - 1'b1;

      if (nx_cmd == C_ACT || nx_cmd == C_REF) rc_q <= WW'(T_RC - 1);
      else if (rc_q != '0) rc_q <= rc_q - 1'b1;

      if (!init_q && wait_q == '0) begin
        if (step_q == 3'd0) sd_cke <= 1'b1;
        if (step_q == 3'd5) init_q <= 1'b1;
        else step_q <= step_q + 1'b1;
      end
      if (nx_cmd == C_LMR) cl3_q <= cfg_cas3;

      if (nx_cmd == C_ACT) begin
        open_q <= 1'b1; obank_q <= nx_ba; orow_q <= nx_a;
      end else if (nx_cmd == C_PRE) begin
        open_q <= 1'b0;
      end

      if (init_q && nx_cmd == C_REF) ref_pend_q <= 1'b0;
      if (init_q) begin
        if (refi_q == '0) begin
          refi_q <= FW'(REFI - 1);
          ref_pend_q <= 1'b1;
        end else begin
          refi_q <= refi_q - 1'b1;
        end
      end

      rsh_q    <= {rsh_q[1:0], cmd_q == C_RD};
      rd_valid <= cap;
      if (cap) rd_data <= sd_dq_in;
    end
  end

  p_ready_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> req_valid);
  p_cke_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q != C_NOP) |-> $past(sd_cke));
  p_no_access_early_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !(cmd_q == C_ACT || cmd_q == C_RD || cmd_q == C_WR));
  p_nop_after_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q != C_NOP) |=> (cmd_q == C_NOP));
  p_rd_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  p_ref_closed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && cmd_q == C_REF) |-> !open_q);
endmodule

// File: tb/tb_sdram_cmd_ctrl.sv
module tb_sdram_cmd_ctrl;
  localparam int REFI = 390, T_RCD = 2, T_RP = 2, T_RC = 6, T_MRD = 2;
  localparam logic [3:0] NOP = 4'b0111, ACT = 4'b0011, RD = 4'b0101, WR = 4'b0100,
                         PRE = 4'b0010, REF = 4'b0001, LMR = 4'b0000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, cfg_cas3, req_valid, req_write, req_ready, rd_valid, init_done;
  logic [23:0] req_addr;
  logic [15:0] req_wdata, rd_data, sd_dq_out, sd_dq_in;
  logic [1:0]  req_wmask, sd_ba, sd_dqm;
  logic [12:0] sd_addr;
  logic sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;

  sdram_cmd_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_cas3(cfg_cas3), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_wmask(req_wmask), .req_ready(req_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .init_done(init_done), .sd_cke(sd_cke),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out),
    .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in));

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string r, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // device model state
  bit bopen[4];
  int brow[4];
  int t_act, t_ref, t_pre, t_lmr, init_idx, cl, last_ref;
  int nact = 0, npre1 = 0, nref = 0, nrw = 0, nacc = 0, maxgap = 0;
  bit prev_cke;
  logic [15:0] mem[int];
  logic [15:0] shadow[int];
  int drv_due[$];
  logic [15:0] drv_dat[$];
  int vld_due[$];
  logic [15:0] hostq[$];
  logic [23:0] cur_a;
  logic [15:0] cur_d;
  logic [1:0]  cur_m;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] merge(logic [15:0] old, logic [15:0] d, logic [1:0] m);
    return {m[1] ? old[15:8] : d[15:8], m[0] ? old[7:0] : d[7:0]};
  endfunction

  always @(negedge clk) begin : model
    int e, k;
    logic [3:0] c;
    logic [15:0] w, x;
    bit ev;
    e = cyc + 1;
    c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    if (!rst_n) begin
      for (int b = 0; b < 4; b++) bopen[b] = 0;
      t_act = -1000; t_ref = -1000; t_pre = -1000; t_lmr = -1000;
      init_idx = 0; cl = 3; prev_cke = 0;
      drv_due.delete(); drv_dat.delete(); vld_due.delete();
      sd_dq_in = 16'h5A5A;
    end else begin
      if (drv_due.size() > 0 && drv_due[0] == cyc) begin
        void'(drv_due.pop_front());
        sd_dq_in = drv_dat.pop_front();
      end else sd_dq_in = 16'h5A5A;
      ev = (vld_due.size() > 0 && vld_due[0] == cyc);
      if (ev) void'(vld_due.pop_front());
      chk(rd_valid == ev, "R7 rd_valid timing", rd_valid, ev);
      if (rd_valid && ev) begin
        x = (hostq.size() > 0) ? hostq.pop_front() : 16'hxxxx;
        chk(rd_data === x, "R7 read data", rd_data, x);
      end
      chk(c inside {NOP, ACT, RD, WR, PRE, REF, LMR}, "R1 legal command code", c, NOP);
      chk(sd_dq_oe == (c == WR), "R8 output enable only with write", sd_dq_oe, c == WR);
      if (c != NOP) chk(sd_cke && prev_cke, "R2 cke high before command", {prev_cke, sd_cke}, 3);
      if (init_done) chk(init_idx == 4, "R2 init_done after sequence", init_idx, 4);
      case (c)
        PRE: begin
          chk(init_idx == 0 || init_idx == 4, "R2 precharge order", init_idx, 4);
          if (init_idx == 0) begin
            chk(sd_addr[10], "R2 first precharge is all-bank", sd_addr[10], 1);
            init_idx = 1;
          end
          if (sd_addr[10]) begin
            for (int b = 0; b < 4; b++) bopen[b] = 0;
          end else begin
            chk(bopen[sd_ba], "R4 single precharge targets open bank", sd_ba, 1);
            bopen[sd_ba] = 0;
            npre1++;
          end
          t_pre = e;
        end
        REF: begin
          if (init_idx == 1 || init_idx == 2) init_idx++;
          else begin
            chk(init_idx == 4, "R2 refresh order", init_idx, 4);
            if (e - last_ref > maxgap) maxgap = e - last_ref;
            last_ref = e;
            nref++;
          end
          chk(!(bopen[0] | bopen[1] | bopen[2] | bopen[3]), "R9 banks closed at refresh",
              {bopen[3], bopen[2], bopen[1], bopen[0]}, 0);
          chk(e - t_pre >= T_RP, "R6 tRP before refresh", e - t_pre, T_RP);
          chk(e - t_act >= T_RC && e - t_ref >= T_RC, "R6 tRC before refresh", e - t_ref, T_RC);
          t_ref = e;
        end
        LMR: begin
          chk(init_idx == 3, "R2 mode load order", init_idx, 3);
          chk(sd_addr[6:4] == (cfg_cas3 ? 3'd3 : 3'd2), "R11 CAS latency field", sd_addr[6:4],
              cfg_cas3 ? 3 : 2);
          chk(sd_addr[3:0] == 4'd0, "R2 burst field", sd_addr[3:0], 0);
          cl = int'(sd_addr[6:4]);
          init_idx = 4; t_lmr = e; last_ref = e;
        end
        ACT: begin
          chk(init_idx == 4, "R2 no activate during init", init_idx, 4);
          chk(sd_ba == cur_a[23:22] && sd_addr == cur_a[21:9], "R3 activate bank/row",
              {sd_ba, sd_addr}, cur_a[23:9]);
          chk(!(bopen[0] | bopen[1] | bopen[2] | bopen[3]), "R4 only one row open", 1, 0);
          chk(e - t_pre >= T_RP, "R6 tRP before activate", e - t_pre, T_RP);
          chk(e - t_act >= T_RC && e - t_ref >= T_RC, "R6 tRC before activate", e - t_act, T_RC);
          chk(e - t_lmr >= T_MRD, "R6 tMRD before activate", e - t_lmr, T_MRD);
          bopen[sd_ba] = 1; brow[sd_ba] = int'(sd_addr); t_act = e; nact++;
        end
        RD, WR: begin
          chk(init_idx == 4, "R2 no access during init", init_idx, 4);
          chk(sd_ba == cur_a[23:22] && sd_addr[8:0] == cur_a[8:0] && !sd_addr[10],
              "R3 access bank/column", {sd_ba, sd_addr}, {cur_a[23:22], 4'b0, cur_a[8:0]});
          chk(bopen[sd_ba] && brow[sd_ba] == int'(cur_a[21:9]), "R3 access hits open row",
              brow[sd_ba], cur_a[21:9]);
          chk(e - t_act >= T_RCD, "R6 tRCD", e - t_act, T_RCD);
          k = int'(cur_a);
          nrw++;
          if (c == RD) begin
            w = mem.exists(k) ? mem[k] : 16'h0;
            drv_due.push_back(e + cl - 1); drv_dat.push_back(w); vld_due.push_back(e + cl);
          end else begin
            chk(sd_dq_out == cur_d && sd_dqm == cur_m, "R8 write data and mask",
                {sd_dqm, sd_dq_out}, {cur_m, cur_d});
            w = mem.exists(k) ? mem[k] : 16'h0;
            mem[k] = merge(w, sd_dq_out, sd_dqm);
          end
        end
        default: ;
      endcase
      prev_cke = sd_cke;
    end
  end

  function automatic logic [23:0] A(int b, int r, int c);
    return {b[1:0], r[12:0], c[8:0]};
  endfunction

  task automatic req(input bit wr, input logic [23:0] a, input logic [15:0] d, input logic [1:0] m);
    int k;
    @(negedge clk);
    cur_a = a; cur_d = d; cur_m = m;
    req_write = wr; req_addr = a; req_wdata = d; req_wmask = m; req_valid = 1'b1;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    nacc++;
    k = int'(a);
    if (wr) shadow[k] = merge(shadow.exists(k) ? shadow[k] : 16'h0, d, m);
    else hostq.push_back(shadow.exists(k) ? shadow[k] : 16'h0);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic sync_ref();
    int n;
    n = nref;
    while (nref == n) @(negedge clk);
  endtask

  task automatic run_set();
    int n;
    sync_ref();
    req(1, A(0, 5, 3), 16'hA1B2, 2'b00);
    req(0, A(0, 5, 3), 0, 0);
    req(1, A(0, 5, 3), 16'hFFFF, 2'b10);           // R8 upper byte masked
    req(0, A(0, 5, 3), 0, 0);
    n = npre1;
    req(1, A(0, 7, 3), 16'h1234, 2'b00);
    chk(npre1 == n + 1, "R4 row change uses single-bank precharge", npre1, n + 1);
    req(0, A(0, 5, 3), 0, 0);
    req(1, A(3, 8191, 511), 16'hBEEF, 2'b00);
    req(0, A(3, 8191, 511), 0, 0);
    req(1, A(1, 0, 0), 16'h0F0F, 2'b01);           // R8 lower byte masked
    n = nact;
    req(0, A(1, 0, 0), 0, 0);
    req(1, A(1, 0, 5), 16'h7777, 2'b00);
    req(0, A(1, 0, 5), 0, 0);
    chk(nact == n, "R5 open-row hits skip activate", nact, n);
    n = nref;
    repeat (1300) @(negedge clk);
    chk(nref - n >= 3, "R9 refresh while idle", nref - n, 3);
    for (int i = 0; i < 60; i++) begin
      req(1, A(2, 4 + (i % 3), i), 16'(i * 97), 2'(i));
      req(0, A(2, 4 + (i % 3), i), 0, 0);
      req(0, A(0, 5, 3), 0, 0);
    end
    repeat (10) @(negedge clk);
    chk(hostq.size() == 0, "R7 all reads returned", hostq.size(), 0);
  endtask

  initial begin
    rst_n = 0; cfg_cas3 = 1; req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0;
    req_wmask = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(sd_cke == 0, "R2 reset cke low", sd_cke, 0);
    chk(init_done == 0, "R2 reset init_done low", init_done, 0);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == NOP, "R1 reset NOP",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, NOP);
    chk(rd_valid == 0 && req_ready == 0, "R10 reset outputs idle", {rd_valid, req_ready}, 0);
    @(negedge clk); rst_n = 1;
    while (!init_done) @(negedge clk);
    chk(init_idx == 4, "R2 init sequence complete", init_idx, 4);
    chk(cl == 3, "R11 latency three programmed", cl, 3);
    run_set();

    @(negedge clk); rst_n = 0; cfg_cas3 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    while (!init_done) @(negedge clk);
    chk(cl == 2, "R11 latency two programmed", cl, 2);
    run_set();

    chk(nrw == nacc, "R10 one command per acceptance", nrw, nacc);
    chk(maxgap <= REFI + 20, "R9 refresh spacing bound", maxgap, REFI + 20);
    $display("test done: total=%0d bad=%0d", total, bad);
    done = 1;
    $finish;
  end

  initial begin
    while (cyc < 150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule